// File: doc/BRIEF.md
# Two-Real-Signal Spectrum Splitter

A complex FFT can transform two independent real signals at once when one of them drives its real input and the other its imaginary input. The output of such a transform is X(n) + jY(n), in which both spectra are mixed. This block takes that output stream and separates it into the two spectra. It uses the conjugate symmetry that every real-input spectrum has.

Bins arrive in natural order, and a start marker flags bin 0. The block stores a whole frame in one half of a ping-pong buffer. Once bin N-1 has been stored, it reads the frame back in natural order. For each bin n it fetches the bin and its mirror m = (N-n) mod N in the same cycle. It then emits the two complex spectra side by side, under one shared valid and a start marker. The next frame can be written into the other half of the buffer while the current one is read out.

Top module: `fft2real_split`

## Requirements
- R1: After a synchronous reset, out_valid and out_sof are 0 and stay 0 until a full frame of N bins has been accepted.
- R2: A bin is accepted when in_valid=1 and either in_sof=1 (the bin is stored as bin 0) or a frame is open. After bin N-1 the frame closes. Bins with in_valid=1 and in_sof=0 while no frame is open are ignored and produce no output.
- R3: With m=(N-n) mod N, the first spectrum for output bin n is a_re = floor((X(n)+X(m))/2) and a_im = floor((Y(n)-Y(m))/2).
- R4: The second spectrum is b_re = floor((Y(n)+Y(m))/2) and b_im = -floor((X(n)-X(m))/2).
- R5: Bins 0 and N/2 pair with themselves, so for them a_im = 0, b_im = 0, a_re = X(n) and b_re = Y(n).
- R6: A frame is emitted as N consecutive cycles with out_valid=1, in bin order 0..N-1, with out_sof=1 only on bin 0. Bin 0 is presented after the second rising edge following the edge that accepted input bin N-1.
- R7: Idle cycles (in_valid=0) inside a frame are allowed, and in_sof is ignored in those cycles. The results do not change.
- R8: An accepted in_sof in the middle of a frame discards the bins received so far and restarts the frame at bin 0.
- R9: Frames may be sent back to back with no idle cycle. Every frame is then emitted completely and in order, with no gap between output frames.
- R10: Outputs are W+1 bits wide, two's complement, and never overflow, including for full-scale inputs -2^(W-1) and 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bin valid |
| in_sof | input | 1 | Marks bin 0 of a frame (with in_valid) |
| in_re | input | W | Real part X(n) of the mixed FFT bin |
| in_im | input | W | Imaginary part Y(n) of the mixed FFT bin |
| out_valid | output | 1 | Output bin valid |
| out_sof | output | 1 | Marks output bin 0 |
| a_re | output | W+1 | First spectrum, real part |
| a_im | output | W+1 | First spectrum, imaginary part |
| b_re | output | W+1 | Second spectrum, real part |
| b_im | output | W+1 | Second spectrum, imaginary part |

## Verification
Two functions can fall in the same clock cycle: the acceptance of the last bin of a new frame into one buffer half, and the readout of the last bin of the previous frame from the other half. The bench provokes this by sending several frames back to back with no idle cycles. Every output bin of each frame is compared against spectra that bench functions compute from the stored input. The bench also checks that out_valid stays high without a break across frame boundaries and that out_sof arrives exactly two edges after the last input bin.

// File: rtl/fft2r_pkg.sv
package fft2r_pkg;
  // read latency of the frame store, in cycles
  localparam int unsigned RAM_LAT = 1;
endpackage

// File: rtl/fft2r_bank_ram.sv
module fft2r_bank_ram #(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/fft2r_frame_ctrl.sv
module fft2r_frame_ctrl #(
  parameter int unsigned N = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sof,
  output logic            we,
  output logic [$clog2(N):0] waddr,
  output logic            rd_valid,
  output logic            rd_first,
  output logic [$clog2(N):0] raddr_dir,
  output logic [$clog2(N):0] raddr_mir
);
  localparam int unsigned LN = $clog2(N);
  localparam logic [LN-1:0] LAST = LN'(N - 1);
  localparam logic [LN-1:0] ONE  = LN'(1);

  logic          open_q;
  logic [LN-1:0] widx_q;
  logic          wbank_q;
  logic          ract_q;
  logic [LN-1:0] ridx_q;
  logic          rbank_q;
  logic          accept;
  logic [LN-1:0] cur_idx;
  logic          frame_done;
  logic [LN-1:0] mir_idx;

  assign accept     = in_valid && (in_sof || open_q);
  assign cur_idx    = in_sof ? '0 : widx_q;
  assign frame_done = accept && (cur_idx == LAST);
  assign we         = accept;
  assign waddr      = {wbank_q, cur_idx};
  assign mir_idx    = (~ridx_q) + ONE;
  assign raddr_dir  = {rbank_q, ridx_q};
  assign raddr_mir  = {rbank_q, mir_idx};
  assign rd_valid   = ract_q;
  assign rd_first   = ract_q && (ridx_q == '0);

  // write side: frame assembly
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      widx_q  <= '0;
      wbank_q <= 1'b0;
    end else if (accept) begin
      if (frame_done) begin
        open_q  <= 1'b0;
        widx_q  <= '0;
        wbank_q <= ~wbank_q;
      end else begin
        open_q  <= 1'b1;
        widx_q  <= cur_idx + ONE;
      end
    end
  end

  // read side: one pass over the finished bank
  always_ff @(posedge clk) begin
    if (rst) begin
      ract_q  <= 1'b0;
      ridx_q  <= '0;
      rbank_q <= 1'b0;
    end else if (frame_done) begin
      ract_q  <= 1'b1;
      ridx_q  <= '0;
      rbank_q <= wbank_q;
    end else if (ract_q) begin
      if (ridx_q == LAST) ract_q <= 1'b0;
      else                ridx_q <= ridx_q + ONE;
    end
  end

  // R9: the previous readout is on its last bin (or idle) whenever a new frame completes
  p_read_done_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!ract_q || ridx_q == LAST));

  // R2: an accepted start marker is followed by a write of bin 1
  p_first_bin_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (!(in_valid && !in_sof) || waddr[LN-1:0] == ONE));
endmodule

// File: rtl/fft2r_butterfly.sv
module fft2r_butterfly #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         q_valid,
  input  logic         q_first,
  input  logic [W-1:0] xd,
  input  logic [W-1:0] yd,
  input  logic [W-1:0] xm,
  input  logic [W-1:0] ym,
  output logic         out_valid,
  output logic         out_sof,
  output logic [W:0]   a_re,
  output logic [W:0]   a_im,
  output logic [W:0]   b_re,
  output logic [W:0]   b_im
);
  logic [W:0] xs, xdf, ys, ydf;
  logic [W:0] x_even, x_odd, y_even, y_odd;

  assign xs  = {xd[W-1], xd} + {xm[W-1], xm};
  assign xdf = {xd[W-1], xd} - {xm[W-1], xm};
  assign ys  = {yd[W-1], yd} + {ym[W-1], ym};
  assign ydf = {yd[W-1], yd} - {ym[W-1], ym};

  assign x_even = $unsigned($signed(xs)  >>> 1);
  assign x_odd  = $unsigned($signed(xdf) >>> 1);
  assign y_even = $unsigned($signed(ys)  >>> 1);
  assign y_odd  = $unsigned($signed(ydf) >>> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      a_re <= '0; a_im <= '0; b_re <= '0; b_im <= '0;
    end else begin
      out_valid <= q_valid;
      out_sof   <= q_first;
      a_re <= x_even;
      a_im <= y_odd;
      b_re <= y_even;
      b_im <= '0 - x_odd;
    end
  end

  // R5: a self-paired bin has no odd part
  p_self_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (q_valid && xd == xm && yd == ym) |=> (a_im == '0 && b_im == '0));

  // R10: halved sums and differences stay within W signed bits
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (a_re[W] == a_re[W-1] && a_im[W] == a_im[W-1] && b_re[W] == b_re[W-1]));
endmodule

// File: rtl/fft2real_split.sv
module fft2real_split #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic [W-1:0] in_re,
  input  logic [W-1:0] in_im,
  output logic         out_valid,
  output logic         out_sof,
  output logic [W:0]   a_re,
  output logic [W:0]   a_im,
  output logic [W:0]   b_re,
  output logic [W:0]   b_im
);
  import fft2r_pkg::*;
  localparam int unsigned AW = $clog2(N) + 1;
  localparam int unsigned DW = 2 * W;

  logic          we;
  logic [AW-1:0] waddr, raddr_dir, raddr_mir;
  logic          rd_valid, rd_first;
  logic [DW-1:0] q [2];
  logic [RAM_LAT:0] vpipe, fpipe;

  fft2r_frame_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .we(we), .waddr(waddr), .rd_valid(rd_valid), .rd_first(rd_first),
    .raddr_dir(raddr_dir), .raddr_mir(raddr_mir)
  );

  // two copies of the store: one read at bin n, one at its mirror
  for (genvar g = 0; g < 2; g++) begin : g_store
    fft2r_bank_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk(clk), .we(we), .waddr(waddr), .wdata({in_re, in_im}),
      .raddr(g == 0 ? raddr_dir : raddr_mir), .q(q[g])
    );
  end

  // align valid and first-bin marker with the store's read latency
  assign vpipe[0] = rd_valid;
  assign fpipe[0] = rd_first;
  for (genvar s = 0; s < RAM_LAT; s++) begin : g_align
    always_ff @(posedge clk) begin
      if (rst) begin
        vpipe[s+1] <= 1'b0;
        fpipe[s+1] <= 1'b0;
      end else begin
        vpipe[s+1] <= vpipe[s];
        fpipe[s+1] <= fpipe[s];
      end
    end
  end

  fft2r_butterfly #(.W(W)) u_bfly (
    .clk(clk), .rst(rst),
    .q_valid(vpipe[RAM_LAT]), .q_first(fpipe[RAM_LAT]),
    .xd(q[0][DW-1:W]), .yd(q[0][W-1:0]),
    .xm(q[1][DW-1:W]), .ym(q[1][W-1:0]),
    .out_valid(out_valid), .out_sof(out_sof),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im)
  );

  // R6: frame start marker only on a valid bin
  p_sof_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  // R6: a frame is emitted without holes; only bin 0 may follow an idle cycle
  p_contig_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> $past(out_valid));
endmodule

// File: tb/test_fft2real_split.sv
module test_fft2real_split;
  localparam int N = 16;
  localparam int W = 8;
  localparam int FR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [W-1:0] in_re = '0, in_im = '0;
  logic out_valid, out_sof;
  logic [W:0] a_re, a_im, b_re, b_im;

  always #10 clk = ~clk;

  fft2real_split #(.N(N), .W(W)) i_fft2real_split (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_sof(out_sof),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im)
  );

  int errors = 0, checks = 0;
  int fx [FR][N];
  int fy [FR][N];
  int sent = 0, got = 0, cap = 0, cyc = 0, last_acc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int half(int v); return v >>> 1; endfunction
  function automatic int mir(int n); return (N - n) % N; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // output monitor: compares every bin against bench-computed spectra
  always @(negedge clk) begin
    if (!rst && got < sent && out_valid) begin
      if (out_sof) begin
        chk(cap == 0, "R6 sof position", cap, 0);
        chk(cyc - last_acc == 2 || got > 0, "R6 latency", cyc - last_acc, 2);
        cap = 0;
      end
      begin
        int n, m, ear, eai, ebr, ebi;
        n = cap; m = mir(n);
        ear = half(fx[got][n] + fx[got][m]);
        eai = half(fy[got][n] - fy[got][m]);
        ebr = half(fy[got][n] + fy[got][m]);
        ebi = -half(fx[got][n] - fx[got][m]);
        if (n == 0 || n == N/2) begin
          chk(int'($signed(a_im)) == 0 && int'($signed(b_im)) == 0 &&
              int'($signed(a_re)) == fx[got][n] && int'($signed(b_re)) == fy[got][n],
              "R5 self-paired bin", int'($signed(a_re)), fx[got][n]);
        end
        chk(int'($signed(a_re)) == ear && int'($signed(a_im)) == eai,
            "R3 first spectrum", int'($signed(a_re)) * 1000 + int'($signed(a_im)), ear * 1000 + eai);
        chk(int'($signed(b_re)) == ebr && int'($signed(b_im)) == ebi,
            "R4 R10 second spectrum", int'($signed(b_re)) * 1000 + int'($signed(b_im)), ebr * 1000 + ebi);
      end
      cap++;
      if (cap == N) begin got++; cap = 0; end
    end else if (!rst && cap != 0 && !out_valid) begin
      chk(0, "R6 R9 output gap inside frame", 0, 1);
      cap = 0; got++;
    end
  end

  task automatic drive_bin(int x, int y, bit sof);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof;
    in_re = W'(x); in_im = W'(y);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // send stored frame k; gap_pct idle cycles; back-to-back when 0 (valid held)
  task automatic send_frame(int k, int gap_pct);
    for (int n = 0; n < N; n++) begin
      while (gap_pct != 0 && ($urandom % 100) < gap_pct) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = $urandom % 2;   // R7: marker without valid
        in_re = $urandom; in_im = $urandom;
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b1; in_sof = (n == 0);
      in_re = W'(fx[k][n]); in_im = W'(fy[k][n]);
      @(posedge clk);
      if (n == N - 1) begin sent++; last_acc = cyc + 1; end
    end
  endtask

  task automatic fill_random(int k);
    for (int n = 0; n < N; n++) begin
      fx[k][n] = int'($signed(W'($urandom)));
      fy[k][n] = int'($signed(W'($urandom)));
    end
  endtask

  task automatic idle(int c);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (c) @(posedge clk);
  endtask

  task automatic wait_out();
    int t = 0;
    while (got < sent && t < 2000) begin @(posedge clk); t++; end
    chk(got == sent, "R6 R9 frames delivered", got, sent);
  endtask

  initial begin
    #3000000;
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(out_sof == 1'b0, "R1 out_sof after reset", out_sof, 0);

    // R2: bins with no open frame are ignored
    for (int i = 0; i < N + 4; i++) drive_bin(i, -i, 1'b0);
    idle(6);
    chk(out_valid == 1'b0, "R2 stray bins ignored", out_valid, 0);

    // R3 R4: random frame; R1 no output before frame complete
    fill_random(0);
    send_frame(0, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 R6 no output one edge after last bin", out_valid, 0);
    wait_out();

    // R10: full-scale extremes
    for (int n = 0; n < N; n++) begin
      fx[1][n] = (n % 3 == 0) ? -(1 << (W-1)) : (1 << (W-1)) - 1;
      fy[1][n] = (n % 2 == 0) ? (1 << (W-1)) - 1 : -(1 << (W-1));
    end
    fx[1][0] = -(1 << (W-1));
    idle(2);
    send_frame(1, 0);
    wait_out();

    // R7: idle cycles inside the frame
    fill_random(2);
    idle(3);
    send_frame(2, 40);
    wait_out();

    // R8: restart mid-frame discards partial bins
    idle(3);
    for (int n = 0; n < N/2; n++) drive_bin(99 - n, n - 50, n == 0);
    fill_random(3);
    send_frame(3, 0);
    wait_out();

    // R9: back-to-back frames, write and readout overlapping
    for (int k = 4; k < FR; k++) fill_random(k);
    idle(2);
    for (int k = 4; k < FR; k++) send_frame(k, 0);
    idle(1);
    wait_out();

    // R2: after the last frame, nothing more is produced
    for (int i = 0; i < 4; i++) drive_bin(7, 7, 1'b0);
    idle(N + 4);
    chk(out_valid == 1'b0, "R2 no output after stray bins", out_valid, 0);
    finish_run();
  end
endmodule